// File: doc/BRIEF.md
# Halt and Bus Release Controller

This block decides when the processor lets go of the system bus. It accepts a level-sensitive stop request (`hold_n`, active low), a level-sensitive bus-float request (`float_req`, active high) and an active-low reset. It tells the instruction sequencer when to stall, and it drives the bus-free indication, the valid-address strobe, and the output enables for the address bus, the data bus and the read/write line. The tri-state buffers themselves sit outside the block.

A stop request takes effect only at an instruction boundary, which the sequencer marks with `seq_last`. A float request releases the address bus and the read/write line for as long as it is held. When the float request ends, one dead resynchronisation cycle follows before the previous activity resumes. When the sequencer is parked in wait-for-interrupt (`seq_wait`), the block also frees the bus.

The controller is a five-state machine:

- **RUN**: normal execution.
- **HALTED**: stopped at a boundary.
- **SLEEP**: wait-for-interrupt.
- **FLOAT**: bus floated.
- **RESYNC**: the dead cycle after a float.

Transitions:

- **RUN→FLOAT** on a registered float request. This has the highest priority.
- **RUN→HALTED** on a registered stop request together with `seq_last`.
- **RUN→SLEEP** on `seq_wait`.
- **HALTED→RUN** when the registered stop request drops.
- **SLEEP→RUN** when `seq_wait` drops.
- **HALTED/SLEEP→FLOAT** on a registered float request.
- **FLOAT→RESYNC** when the registered float request drops.
- **RESYNC→FLOAT** if the float request is back.
- **RESYNC→(state held before the float)** otherwise.

Both `hold_n` and `float_req` pass through one synchroniser flop (`SYNC_STAGES` = 1) before the machine uses them. All timings below assume that default.

Top module: `bus_release_ctl`

## Requirements
- R1: While `rst_n` is low, every one of the following holds regardless of other inputs: `mem_valid`=0, `bus_free`=0, `dat_en`=0, `dir_read`=1, `adr_en`=1, `dir_en`=1, `boot_vec`=1 (address forced to the reset vector), and `seq_stall`=1.
- R2: In RUN, the following hold: `bus_free`=0, `seq_stall`=0, `adr_en`=1, `dir_en`=1, `mem_valid` equals `seq_vma`, `dat_en` equals `seq_wr`, and `dir_read` equals the inverse of `seq_wr`.
- R3: If `hold_n` is low at clock edge k, and `seq_last` is high at edge k+1, then `bus_free` is high from edge k+1 on. That is the cycle right after the final instruction cycle.
- R4: A stop request first registered at the same edge that closes a `seq_last` cycle does not halt at that boundary. `bus_free` stays low until the next `seq_last` cycle.
- R5: While halted or sleeping, the following hold: `bus_free`=1, `mem_valid`=0, `adr_en`=0, `dat_en`=0, `dir_en`=0, and `seq_stall`=1.
- R6: If `hold_n` is high at edge j while halted, `bus_free` and `seq_stall` both fall at edge j+1, in the same cycle.
- R7: If `float_req` is high at edge k, the following hold from edge k+1 on: `adr_en`=0, `dir_en`=0, `dat_en`=0, `mem_valid`=0, `bus_free`=0, and `seq_stall`=1. This applies even when halted.
- R8: If `float_req` is low at edge m after a float, edge m+1 starts exactly one resync cycle. In it, `adr_en`=1, `dir_en`=1, `dir_read`=1, `mem_valid`=0, `bus_free`=0, and `seq_stall`=1. From edge m+2 the state held before the float resumes.
- R9: A `seq_wait` high at an edge in RUN enters SLEEP at that edge, with the R5 outputs. A `seq_wait` low at an edge in SLEEP returns to RUN at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 1 | Stop request, active low, level sensitive |
| float_req | input | 1 | Bus float request, active high, level sensitive |
| seq_last | input | 1 | Sequencer is in the last cycle of an instruction |
| seq_wait | input | 1 | Sequencer is parked in wait-for-interrupt |
| seq_vma | input | 1 | Sequencer presents a valid address this cycle |
| seq_wr | input | 1 | Sequencer writes this cycle |
| bus_free | output | 1 | Bus released by the processor |
| mem_valid | output | 1 | Valid memory address strobe |
| adr_en | output | 1 | Address bus output enable |
| dat_en | output | 1 | Data bus output enable |
| dir_en | output | 1 | Read/write line output enable |
| dir_read | output | 1 | Read/write line level, 1 = read |
| boot_vec | output | 1 | Force the reset vector onto the address bus |
| seq_stall | output | 1 | Hold the sequencer |

## Verification
Stop requests are applied at two different instants relative to the `seq_last` cycle. An early request shows that the halt lands right after the boundary. A request registered at the boundary itself shows that it is deferred by a full instruction rather than taken mid-instruction. Float requests are issued both from RUN and from HALTED. These tell apart correct precedence over the halted outputs, the single dead cycle on release, and the return to the state held before the float. Pass-through patterns of `seq_vma` and `seq_wr` in RUN, a wait-for-interrupt round trip, and a reset applied while halted complete the set.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_HALTED = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_FLOAT  = 3'd3,
        ST_RESYNC = 3'd4
    } brc_state_t;

    typedef struct packed {
        logic bus_free;
        logic mem_valid;
        logic adr_en;
        logic dat_en;
        logic dir_en;
        logic dir_read;
        logic boot_vec;
        logic seq_stall;
    } brc_out_t;
endpackage

// File: rtl/brc_sync.sv
`timescale 1ns/1ps
module brc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[LAST];
endmodule

// File: rtl/brc_fsm.sv
`timescale 1ns/1ps
module brc_fsm
    import brc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_q,
    input  logic       float_q,
    input  logic       seq_last,
    input  logic       seq_wait,
    output brc_state_t state
);
    brc_state_t state_nx;
    brc_state_t back_q;
    brc_state_t back_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            back_q <= ST_RUN;
        end else begin
            state  <= state_nx;
            back_q <= back_nx;
        end
    end

    always_comb begin
        state_nx = state;
        back_nx  = back_q;
        unique case (state)
            ST_RUN: begin
                if (float_q) begin
                    state_nx = ST_FLOAT;
                    back_nx  = ST_RUN;
                end else if (stop_q && seq_last) begin
                    state_nx = ST_HALTED;
                end else if (seq_wait) begin
                    state_nx = ST_SLEEP;
                end
            end
            ST_HALTED: begin
                if (float_q) begin
                    state_nx = ST_FLOAT;
                    back_nx  = ST_HALTED;
                end else if (!stop_q) begin
                    state_nx = ST_RUN;
                end
            end
            ST_SLEEP: begin
                if (float_q) begin
                    state_nx = ST_FLOAT;
                    back_nx  = ST_SLEEP;
                end else if (!seq_wait) begin
                    state_nx = ST_RUN;
                end
            end
            ST_FLOAT: begin
                if (!float_q) state_nx = ST_RESYNC;
            end
            ST_RESYNC: begin
                if (float_q) state_nx = ST_FLOAT;
                else         state_nx = back_q;
            end
            default: state_nx = ST_RUN;
        endcase
    end
endmodule

// File: rtl/brc_outdec.sv
`timescale 1ns/1ps
module brc_outdec
    import brc_pkg::*;
(
    input  logic       rst_n,
    input  brc_state_t state,
    input  logic       seq_vma,
    input  logic       seq_wr,
    output brc_out_t   o
);
    always_comb begin
        o = '{bus_free: 1'b0, mem_valid: 1'b0, adr_en: 1'b0, dat_en: 1'b0,
              dir_en: 1'b0, dir_read: 1'b1, boot_vec: 1'b0, seq_stall: 1'b1};
        if (!rst_n) begin
            o.adr_en   = 1'b1;
            o.dir_en   = 1'b1;
            o.boot_vec = 1'b1;
        end else begin
            unique case (state)
                ST_RUN: begin
                    o.mem_valid = seq_vma;
                    o.adr_en    = 1'b1;
                    o.dir_en    = 1'b1;
                    o.dat_en    = seq_wr;
                    o.dir_read  = ~seq_wr;
                    o.seq_stall = 1'b0;
                end
                ST_HALTED, ST_SLEEP: begin
                    o.bus_free = 1'b1;
                end
                ST_FLOAT: begin
                    o.bus_free = 1'b0;
                end
                ST_RESYNC: begin
                    o.adr_en = 1'b1;
                    o.dir_en = 1'b1;
                end
                default: o.seq_stall = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/bus_release_ctl.sv
`timescale 1ns/1ps
module bus_release_ctl
    import brc_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n,
    input  logic float_req,
    input  logic seq_last,
    input  logic seq_wait,
    input  logic seq_vma,
    input  logic seq_wr,
    output logic bus_free,
    output logic mem_valid,
    output logic adr_en,
    output logic dat_en,
    output logic dir_en,
    output logic dir_read,
    output logic boot_vec,
    output logic seq_stall
);
    localparam int NREQ = 2;

    logic [NREQ-1:0] req_raw;
    logic [NREQ-1:0] req_q;
    brc_state_t      state;
    brc_out_t        outs;

    assign req_raw = {float_req, ~hold_n};

    brc_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_raw),
        .q     (req_q)
    );

    brc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_q   (req_q[0]),
        .float_q  (req_q[1]),
        .seq_last (seq_last),
        .seq_wait (seq_wait),
        .state    (state)
    );

    brc_outdec u_dec (
        .rst_n   (rst_n),
        .state   (state),
        .seq_vma (seq_vma),
        .seq_wr  (seq_wr),
        .o       (outs)
    );

    assign bus_free  = outs.bus_free;
    assign mem_valid = outs.mem_valid;
    assign adr_en    = outs.adr_en;
    assign dat_en    = outs.dat_en;
    assign dir_en    = outs.dir_en;
    assign dir_read  = outs.dir_read;
    assign boot_vec  = outs.boot_vec;
    assign seq_stall = outs.seq_stall;
endmodule

// File: rtl/bus_release_chk.sv
`timescale 1ns/1ps
module bus_release_chk (
    input logic clk,
    input logic rst_n,
    input logic seq_last,
    input logic seq_wait,
    input logic seq_vma,
    input logic seq_wr,
    input logic bus_free,
    input logic mem_valid,
    input logic adr_en,
    input logic dat_en,
    input logic dir_en,
    input logic dir_read,
    input logic boot_vec,
    input logic seq_stall
);
    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_outputs_chk: assert (!mem_valid && !bus_free && !dat_en && dir_read
                                       && adr_en && dir_en && boot_vec && seq_stall);
        end
    end

    // R2
    running_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_stall |-> (adr_en && dir_en && !bus_free && mem_valid == seq_vma
                        && dat_en == seq_wr && dir_read == !seq_wr));

    // R5
    released_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> (!mem_valid && !adr_en && !dat_en && !dir_en && seq_stall));

    // R7
    float_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adr_en && !bus_free) |-> (!mem_valid && !dat_en && !dir_en && seq_stall));

    // R8
    resync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_en && seq_stall && !bus_free) |=> !(adr_en && seq_stall && !bus_free));

    // R3
    free_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> ($past(seq_last) || $past(seq_wait)
                             || $past(adr_en && seq_stall)));
endmodule

bind bus_release_ctl bus_release_chk u_chk (.*);

// File: tb/bus_release_ctl_test.sv
`timescale 1ns/1ps
module bus_release_ctl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_n = 1'b1;
    logic float_req = 1'b0;
    logic seq_last = 1'b0;
    logic seq_wait = 1'b0;
    logic seq_vma = 1'b0;
    logic seq_wr = 1'b0;
    logic bus_free, mem_valid, adr_en, dat_en, dir_en, dir_read, boot_vec, seq_stall;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_release_ctl uut (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .float_req(float_req),
        .seq_last(seq_last), .seq_wait(seq_wait), .seq_vma(seq_vma), .seq_wr(seq_wr),
        .bus_free(bus_free), .mem_valid(mem_valid), .adr_en(adr_en), .dat_en(dat_en),
        .dir_en(dir_en), .dir_read(dir_read), .boot_vec(boot_vec), .seq_stall(seq_stall)
    );

    // packed view: {bus_free,mem_valid,adr_en,dat_en,dir_en,dir_read,boot_vec,seq_stall}
    function automatic logic [7:0] outv();
        return {bus_free, mem_valid, adr_en, dat_en, dir_en, dir_read, boot_vec, seq_stall};
    endfunction

    task automatic check(string req, logic [7:0] exp);
        logic [7:0] act;
        act = outv();
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    localparam logic [7:0] O_RESET  = 8'b0010_1111;
    localparam logic [7:0] O_FREE   = 8'b1000_0101;
    localparam logic [7:0] O_FLOAT  = 8'b0000_0101;
    localparam logic [7:0] O_RESYNC = 8'b0010_1101;

    function automatic logic [7:0] o_run(logic v, logic w);
        return {1'b0, v, 1'b1, w, 1'b1, ~w, 1'b0, 1'b0};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        #1;
        check("R1 reset", O_RESET);
        step();
        check("R1 reset held", O_RESET);
        rst_n = 1'b1;
        step();
        check("R2 after reset", o_run(seq_vma, seq_wr));
    endtask

    task automatic t_passthru();
        for (int i = 0; i < 4; i++) begin
            seq_vma = i[0];
            seq_wr  = i[1];
            #1;
            check("R2 passthru", o_run(i[0], i[1]));
            step();
        end
        seq_vma = 1'b0;
        seq_wr  = 1'b0;
    endtask

    task automatic t_halt_early();
        hold_n = 1'b0;
        step();
        check("R3 not yet", o_run(1'b0, 1'b0));
        seq_last = 1'b1;
        step();
        seq_last = 1'b0;
        check("R3 halted after last", O_FREE);
        step();
        check("R5 halted outputs", O_FREE);
        hold_n = 1'b1;
        step();
        check("R6 still halted", O_FREE);
        step();
        check("R6 resumed", o_run(1'b0, 1'b0));
    endtask

    task automatic t_halt_late();
        hold_n = 1'b0;
        seq_last = 1'b1;
        step();
        seq_last = 1'b0;
        check("R4 late request ignored", o_run(1'b0, 1'b0));
        step();
        step();
        check("R4 mid instruction", o_run(1'b0, 1'b0));
        seq_last = 1'b1;
        step();
        seq_last = 1'b0;
        check("R4 halt at next boundary", O_FREE);
        hold_n = 1'b1;
        step();
        step();
        check("R6 resumed", o_run(1'b0, 1'b0));
    endtask

    task automatic t_float_run();
        float_req = 1'b1;
        step();
        check("R7 latency", o_run(1'b0, 1'b0));
        step();
        check("R7 floated", O_FLOAT);
        float_req = 1'b0;
        step();
        check("R7 float tail", O_FLOAT);
        step();
        check("R8 resync", O_RESYNC);
        step();
        check("R8 resumed run", o_run(1'b0, 1'b0));
    endtask

    task automatic t_float_halted();
        hold_n = 1'b0;
        step();
        seq_last = 1'b1;
        step();
        seq_last = 1'b0;
        check("R5 halted", O_FREE);
        float_req = 1'b1;
        step();
        check("R7 halted before float", O_FREE);
        step();
        check("R7 precedence over halt", O_FLOAT);
        float_req = 1'b0;
        step();
        step();
        check("R8 resync from halt", O_RESYNC);
        step();
        check("R8 back to halted", O_FREE);
        hold_n = 1'b1;
        step();
        step();
        check("R6 resumed", o_run(1'b0, 1'b0));
    endtask

    task automatic t_sleep();
        seq_wait = 1'b1;
        step();
        check("R9 sleep entered", O_FREE);
        step();
        check("R9 sleep held", O_FREE);
        seq_wait = 1'b0;
        step();
        check("R9 sleep left", o_run(1'b0, 1'b0));
    endtask

    task automatic t_reset_halted();
        hold_n = 1'b0;
        step();
        seq_last = 1'b1;
        step();
        seq_last = 1'b0;
        check("R5 halted", O_FREE);
        rst_n = 1'b0;
        #1;
        check("R1 reset while halted", O_RESET);
        hold_n = 1'b1;
        step();
        rst_n = 1'b1;
        step();
        check("R2 run after reset", o_run(1'b0, 1'b0));
    endtask

    initial begin
        #2;
        do_reset();
        t_passthru();
        t_halt_early();
        t_halt_late();
        t_float_run();
        t_float_halted();
        t_sleep();
        t_reset_halted();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #40000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule